// File: doc/BRIEF.md
# Synchronous Burst Static Memory Cycle Controller

This block is the cycle controller, burst sequencer and data path of a synchronous burst static memory with a 64-bit word split into eight byte lanes. On every rising clock edge it classifies the sampled controls as one of six operations. These are deselect, begin a read, begin a write, step to the next burst address, stay at the current address, or snooze. It then reads or writes a small internal word array. Two address strobes can open a cycle: a processor-side strobe, which is gated by the primary chip enable and always opens a read, and a chipset-side strobe, which opens a write when write controls are asserted. Writes can be global or byte-masked.

Read data leaves through `rd_data_o`, with `rd_drive_o` as the enable for the pad-ring tri-state buffer. A static select picks between flow-through timing, where data is visible after the access edge, and pipelined timing, where data passes through an output register and is visible one edge later. The output enable acts without the clock. A snooze input freezes the block while keeping its contents. After snooze is released, a recovery window of `WAKE_CYC` edges follows, and any new cycle started in it is dropped. The burst order is chosen by the parameter `INTERLEAVE`. With 1 the low two address bits are the start bits XOR a 2-bit count. With 0 they are the start bits plus the count, modulo 4.

Top module: `sync_burst_sram`

## Requirements
- R1: When `en_n_i` is high the processor strobe `cpu_stb_n_i` is ignored and the edge acts as if it were high. If `set_stb_n_i` is low while `en_n_i` is high, the block is deselected and reads nothing until a new cycle begins.
- R2: `en_hi_i` (active high) and `en_lo_n_i` (active low) matter only on an edge where an effective strobe is low. If either of them is inactive on such an edge, the block is deselected.
- R3: A selected edge with `cpu_stb_n_i` low and `en_n_i` low begins a read of `addr_i`, whatever the write inputs are.
- R4: With both strobes high, `adv_n_i` high and a write asserted, an active cycle writes the current burst address. This is how a processor-opened cycle performs its write one edge later.
- R5: A selected edge opened by `set_stb_n_i` (processor strobe high or ignored) begins a write to `addr_i` if a write is asserted, and a read of `addr_i` otherwise.
- R6: With both strobes high and a cycle active, `adv_n_i` low moves to the next burst address and `adv_n_i` high stays on the current one. With `INTERLEAVE`=1 (the default) the address is {start[AW-1:2], start[1:0] XOR count}, and the count goes up by one per step and wraps after 3.
- R7: `all_wr_n_i` low writes all eight bytes, whatever `byte_wr_n_i` and `byte_en_n_i` are.
- R8: With `all_wr_n_i` high and `byte_wr_n_i` low, byte lane i (bits 8i+7..8i) is written only where `byte_en_n_i[i]` is low. With `byte_wr_n_i` high, or with all byte enables high, the edge is a read.
- R9: `rd_drive_o` is high only while `oe_n_i` is low and a read result is being presented. It is low for writes and deselect, and `rd_data_o` is zero whenever `rd_drive_o` is low.
- R10: With `pipe_sel_i` low, the word read at an edge is presented right after that edge. With `pipe_sel_i` high it is presented after the following edge, through an output register.
- R11: While `sleep_i` is high, the edge performs no access, ignores every other input, deselects the block and keeps the stored words.
- R12: For the first `WAKE_CYC` edges after `sleep_i` falls, both strobes are dropped, so no new cycle can begin.
- R13: While `rst_n` is low, the block is deselected and `rd_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | External word address |
| wdata_i | input | 8*NBYTE | Write data |
| cpu_stb_n_i | input | 1 | Processor address strobe, active low |
| set_stb_n_i | input | 1 | Chipset address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| en_n_i | input | 1 | Primary chip enable, active low |
| en_hi_i | input | 1 | Secondary chip enable, active high |
| en_lo_n_i | input | 1 | Tertiary chip enable, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| byte_wr_n_i | input | 1 | Byte-write enable, active low |
| byte_en_n_i | input | NBYTE | Per-lane byte enables, active low |
| oe_n_i | input | 1 | Output enable, asynchronous, active low |
| pipe_sel_i | input | 1 | Static: 1 pipelined, 0 flow-through |
| sleep_i | input | 1 | Snooze, active high |
| rd_data_o | output | 8*NBYTE | Read data, zero when not driven |
| rd_drive_o | output | 1 | Data bus drive enable |

## Verification
A wrong burst count or start address shows as a wrong word at `rd_data_o` on the very next read slot. That is the same edge in flow-through mode and one edge later in pipelined mode. A wrong decode, such as a write taken for a read or a strobe not gated by its enable, shows as `rd_drive_o` asserted or missing in that slot. A wrong byte mask or a write lost during snooze stays latent in the array until the word is read back, so every write in the bench is followed by a read of the same address. A wrong recovery count shows as a read appearing one window edge too early or too late.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [2:0] {
        OP_SLEEP,
        OP_DESEL,
        OP_START_RD,
        OP_START_WR,
        OP_STEP,
        OP_STAY
    } op_e;
endpackage

// File: rtl/sbs_cycle_decode.sv
module sbs_cycle_decode
    import sbs_pkg::*;
#(
    parameter int NBYTE = 8
) (
    input  logic             cpu_stb_n_i,
    input  logic             set_stb_n_i,
    input  logic             adv_n_i,
    input  logic             en_n_i,
    input  logic             en_hi_i,
    input  logic             en_lo_n_i,
    input  logic             all_wr_n_i,
    input  logic             byte_wr_n_i,
    input  logic [NBYTE-1:0] byte_en_n_i,
    input  logic             sleep_i,
    input  logic             wake_busy_i,
    output op_e              op_o,
    output logic             wr_o,
    output logic [NBYTE-1:0] byte_mask_o
);
    logic sel;
    logic cpu_go;
    logic set_go;

    always_comb begin
        wr_o        = !all_wr_n_i || (!byte_wr_n_i && !(&byte_en_n_i));
        byte_mask_o = all_wr_n_i ? (~byte_en_n_i & {NBYTE{!byte_wr_n_i}}) : '1;
        sel         = en_hi_i && !en_lo_n_i;
        // the processor strobe only counts under the primary enable
        cpu_go      = !cpu_stb_n_i && !en_n_i && !wake_busy_i;
        set_go      = !set_stb_n_i && !wake_busy_i;
        if (sleep_i) begin
            op_o = OP_SLEEP;
        end else if (cpu_go) begin
            op_o = sel ? OP_START_RD : OP_DESEL;
        end else if (set_go) begin
            if (!en_n_i && sel) begin
                op_o = wr_o ? OP_START_WR : OP_START_RD;
            end else begin
                op_o = OP_DESEL;
            end
        end else begin
            op_o = adv_n_i ? OP_STAY : OP_STEP;
        end
    end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int AW         = 6,
    parameter bit INTERLEAVE = 1'b1
) (
    input  logic [AW-1:0] base_i,
    input  logic [1:0]    cnt_i,
    output logic [AW-1:0] addr_o
);
    logic [1:0] low;

    generate
        if (INTERLEAVE) begin : g_xor
            assign low = base_i[1:0] ^ cnt_i;
        end else begin : g_lin
            assign low = base_i[1:0] + cnt_i;
        end
    endgenerate

    assign addr_o = {base_i[AW-1:2], low};
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
    parameter int AW    = 6,
    parameter int NBYTE = 8
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [NBYTE-1:0]   wmask_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [NBYTE*8-1:0] wdata_i,
    input  logic [AW-1:0]      raddr_i,
    output logic [NBYTE*8-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NBYTE * 8;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (wmask_i[b]) begin
                    mem[waddr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
                end
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int AW         = 6,
    parameter int NBYTE      = 8,
    parameter bit INTERLEAVE = 1'b1,
    parameter int WAKE_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr_i,
    input  logic [NBYTE*8-1:0] wdata_i,
    input  logic               cpu_stb_n_i,
    input  logic               set_stb_n_i,
    input  logic               adv_n_i,
    input  logic               en_n_i,
    input  logic               en_hi_i,
    input  logic               en_lo_n_i,
    input  logic               all_wr_n_i,
    input  logic               byte_wr_n_i,
    input  logic [NBYTE-1:0]   byte_en_n_i,
    input  logic               oe_n_i,
    input  logic               pipe_sel_i,
    input  logic               sleep_i,
    output logic [NBYTE*8-1:0] rd_data_o,
    output logic               rd_drive_o
);
    localparam int DW = NBYTE * 8;
    localparam int WW = $clog2(WAKE_CYC + 1);

    typedef struct packed {
        logic          act;
        logic          rd;
        logic [AW-1:0] base;
        logic [1:0]    cnt;
        logic [WW-1:0] wake;
        logic          pv;
        logic [DW-1:0] pdata;
    } st_t;

    st_t st_d, st_q;

    op_e              op;
    logic             wr;
    logic [NBYTE-1:0] byte_mask;
    logic             wake_busy;
    logic             rd_now;
    logic             mem_we;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic [DW-1:0]    rd_word;
    logic             present;
    logic [DW-1:0]    present_word;

    assign wake_busy = (st_q.wake != '0);
    assign rd_now    = st_q.rd;

    sbs_cycle_decode #(.NBYTE(NBYTE)) u_decode (
        .cpu_stb_n_i (cpu_stb_n_i),
        .set_stb_n_i (set_stb_n_i),
        .adv_n_i     (adv_n_i),
        .en_n_i      (en_n_i),
        .en_hi_i     (en_hi_i),
        .en_lo_n_i   (en_lo_n_i),
        .all_wr_n_i  (all_wr_n_i),
        .byte_wr_n_i (byte_wr_n_i),
        .byte_en_n_i (byte_en_n_i),
        .sleep_i     (sleep_i),
        .wake_busy_i (wake_busy),
        .op_o        (op),
        .wr_o        (wr),
        .byte_mask_o (byte_mask)
    );

    // address of the access made at the coming edge
    sbs_burst_seq #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_seq_next (
        .base_i (st_d.base),
        .cnt_i  (st_d.cnt),
        .addr_o (waddr)
    );

    // address of the access made at the last edge
    sbs_burst_seq #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_seq_cur (
        .base_i (st_q.base),
        .cnt_i  (st_q.cnt),
        .addr_o (raddr)
    );

    sbs_mem_array #(.AW(AW), .NBYTE(NBYTE)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .wmask_i (byte_mask),
        .waddr_i (waddr),
        .wdata_i (wdata_i),
        .raddr_i (raddr),
        .rdata_o (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rd    = 1'b0;
        st_d.pv    = st_q.rd;
        st_d.pdata = rd_word;
        mem_we     = 1'b0;
        if (op == OP_SLEEP) begin
            st_d.wake = WW'(WAKE_CYC);
        end else if (wake_busy) begin
            st_d.wake = st_q.wake - 1'b1;
        end
        case (op)
            OP_SLEEP, OP_DESEL: begin
                st_d.act = 1'b0;
            end
            OP_START_RD: begin
                st_d.act  = 1'b1;
                st_d.base = addr_i;
                st_d.cnt  = 2'd0;
                st_d.rd   = 1'b1;
            end
            OP_START_WR: begin
                st_d.act  = 1'b1;
                st_d.base = addr_i;
                st_d.cnt  = 2'd0;
                mem_we    = 1'b1;
            end
            OP_STEP: begin
                if (st_q.act) begin
                    st_d.cnt = st_q.cnt + 2'd1;
                    mem_we   = wr;
                    st_d.rd  = !wr;
                end
            end
            default: begin
                if (st_q.act) begin
                    mem_we  = wr;
                    st_d.rd = !wr;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        present      = pipe_sel_i ? st_q.pv : st_q.rd;
        present_word = pipe_sel_i ? st_q.pdata : rd_word;
        rd_drive_o   = present && !oe_n_i;
        rd_data_o    = rd_drive_o ? present_word : '0;
    end
endmodule

// File: rtl/sbs_chk.sv
module sbs_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_stb_n_i,
    input logic set_stb_n_i,
    input logic en_n_i,
    input logic en_hi_i,
    input logic en_lo_n_i,
    input logic all_wr_n_i,
    input logic sleep_i,
    input logic pipe_sel_i,
    input logic rd_drive_o,
    input logic rd_now,
    input logic wake_busy
);
    logic calm;
    assign calm = !sleep_i && !wake_busy;

    AST_GATED_CPU_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb_n_i && en_n_i && calm) |=> !rd_now); // R1

    AST_SIDE_ENABLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb_n_i && !en_n_i && (!en_hi_i || en_lo_n_i) && calm) |=> !rd_now); // R2

    AST_CPU_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n_i && !en_n_i && en_hi_i && !en_lo_n_i && calm) |=> rd_now); // R3

    AST_SET_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n_i && !set_stb_n_i && !en_n_i && en_hi_i && !en_lo_n_i
         && !all_wr_n_i && calm) |=> !rd_now); // R5

    AST_PIPE_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_sel_i && rd_drive_o) |-> $past(rd_now)); // R10

    AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !rd_now); // R11

    AST_WAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_busy && !sleep_i) |=> !rd_now); // R12
endmodule

bind sync_burst_sram sbs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_stb_n_i (cpu_stb_n_i),
    .set_stb_n_i (set_stb_n_i),
    .en_n_i      (en_n_i),
    .en_hi_i     (en_hi_i),
    .en_lo_n_i   (en_lo_n_i),
    .all_wr_n_i  (all_wr_n_i),
    .sleep_i     (sleep_i),
    .pipe_sel_i  (pipe_sel_i),
    .rd_drive_o  (rd_drive_o),
    .rd_now      (rd_now),
    .wake_busy   (wake_busy)
);

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
    localparam int PER  = 10;
    localparam int AW   = 6;
    localparam int WAKE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [63:0] wdata_i = '0;
    logic        cpu_stb_n_i = 1'b1, set_stb_n_i = 1'b0, adv_n_i = 1'b1;
    logic        en_n_i = 1'b1, en_hi_i = 1'b1, en_lo_n_i = 1'b0;
    logic        all_wr_n_i = 1'b1, byte_wr_n_i = 1'b1;
    logic [7:0]  byte_en_n_i = 8'hff;
    logic        oe_n_i = 1'b0, pipe_sel_i = 1'b0, sleep_i = 1'b0;
    logic [63:0] rd_data_o;
    logic        rd_drive_o;

    sync_burst_sram #(.AW(AW), .NBYTE(8), .INTERLEAVE(1'b1), .WAKE_CYC(WAKE)) i_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .cpu_stb_n_i(cpu_stb_n_i), .set_stb_n_i(set_stb_n_i), .adv_n_i(adv_n_i),
        .en_n_i(en_n_i), .en_hi_i(en_hi_i), .en_lo_n_i(en_lo_n_i),
        .all_wr_n_i(all_wr_n_i), .byte_wr_n_i(byte_wr_n_i), .byte_en_n_i(byte_en_n_i),
        .oe_n_i(oe_n_i), .pipe_sel_i(pipe_sel_i), .sleep_i(sleep_i),
        .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
    );

    always #(PER/2) clk = ~clk;

    int edge_no = 0;
    always @(posedge clk) edge_no <= edge_no + 1;

    int checks = 0;
    int errors = 0;
    string tag = "R13";

    typedef struct {
        int          due;
        logic        drv;
        logic [63:0] dat;
        string       req;
    } exp_t;
    exp_t sb[$];

    // reference model state
    logic [63:0] ref_mem [64];
    logic        m_act = 1'b0;
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    int          m_wake = 0;

    function automatic logic [5:0] baddr(logic [5:0] b, logic [1:0] c);
        return {b[5:2], b[1:0] ^ c};
    endfunction

    function automatic logic [63:0] pat(int a);
        return {8{8'(a * 7 + 3)}} ^ 64'h0123_4567_89ab_cdef;
    endfunction

    task automatic cyc(input logic cpu_n, input logic set_n, input logic adv_n,
                       input logic en_n, input logic en_hi, input logic en_lo_n,
                       input logic aw_n, input logic bw_n, input logic [7:0] ben_n,
                       input logic [5:0] a, input logic [63:0] wd,
                       input logic oe_n, input logic slp);
        logic        wr, sel, cgo, sgo, rd;
        logic [63:0] m64;
        logic [5:0]  ax;
        exp_t        e;
        @(negedge clk);
        cpu_stb_n_i = cpu_n; set_stb_n_i = set_n; adv_n_i = adv_n;
        en_n_i = en_n; en_hi_i = en_hi; en_lo_n_i = en_lo_n;
        all_wr_n_i = aw_n; byte_wr_n_i = bw_n; byte_en_n_i = ben_n;
        addr_i = a; wdata_i = wd; oe_n_i = oe_n; sleep_i = slp;
        wr = !aw_n || (!bw_n && ben_n != 8'hff);
        for (int i = 0; i < 8; i++) m64[i*8 +: 8] = (!aw_n || (!bw_n && !ben_n[i])) ? 8'hff : 8'h00;
        rd = 1'b0;
        if (slp) begin
            m_act = 1'b0;
            m_wake = WAKE;
        end else begin
            cgo = !cpu_n && !en_n && m_wake == 0;
            sgo = !set_n && m_wake == 0;
            if (m_wake > 0) m_wake--;
            sel = en_hi && !en_lo_n;
            if (cgo) begin
                m_act = sel;
                if (sel) begin m_base = a; m_cnt = 0; rd = 1'b1; end
            end else if (sgo) begin
                m_act = !en_n && sel;
                if (m_act) begin
                    m_base = a; m_cnt = 0;
                    if (wr) ref_mem[a] = (ref_mem[a] & ~m64) | (wd & m64);
                    else rd = 1'b1;
                end
            end else if (m_act) begin
                if (!adv_n) m_cnt = m_cnt + 2'd1;
                ax = baddr(m_base, m_cnt);
                if (wr) ref_mem[ax] = (ref_mem[ax] & ~m64) | (wd & m64);
                else rd = 1'b1;
            end
        end
        e.due = edge_no + (pipe_sel_i ? 2 : 1);
        e.drv = rd && !oe_n;
        e.dat = e.drv ? ref_mem[baddr(m_base, m_cnt)] : 64'h0;
        e.req = tag;
        sb.push_back(e);
    endtask

    task automatic rd_cpu(input logic [5:0] a);
        cyc(0, 1, 1, 0, 1, 0, 1, 1, 8'hff, a, 64'h0, 0, 0);
    endtask
    task automatic wr_set(input logic [5:0] a, input logic [63:0] wd);
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 8'hff, a, wd, 0, 0);
    endtask
    task automatic adv_rd();
        cyc(1, 1, 0, 0, 1, 0, 1, 1, 8'hff, 6'd0, 64'h0, 0, 0);
    endtask
    task automatic adv_wr(input logic [63:0] wd);
        cyc(1, 1, 0, 0, 1, 0, 0, 1, 8'hff, 6'd0, wd, 0, 0);
    endtask
    task automatic hold_rd();
        cyc(1, 1, 1, 0, 1, 0, 1, 1, 8'hff, 6'd0, 64'h0, 0, 0);
    endtask
    task automatic desel();
        cyc(1, 0, 1, 1, 1, 0, 1, 1, 8'hff, 6'd0, 64'h0, 0, 0);
    endtask

    // monitor: compares each expected slot once its edge has passed
    initial begin
        forever begin
            @(posedge clk);
            #(PER/4);
            while (sb.size() > 0 && sb[0].due <= edge_no) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.due != edge_no || rd_drive_o !== e.drv || rd_data_o !== e.dat) begin
                    errors++;
                    $display("FAIL %s edge %0d: drive=%b data=%h expected drive=%b data=%h",
                             e.req, edge_no, rd_drive_o, rd_data_o, e.drv, e.dat);
                end
            end
        end
    end

    task automatic do_reset(input logic pipe);
        @(negedge clk);
        rst_n = 1'b0;
        pipe_sel_i = pipe;
        cpu_stb_n_i = 1'b1; set_stb_n_i = 1'b0; en_n_i = 1'b1; oe_n_i = 1'b0; sleep_i = 1'b0;
        m_act = 1'b0; m_wake = 0;
        @(negedge clk);
        checks++; // R13
        if (rd_drive_o !== 1'b0 || rd_data_o !== 64'h0) begin
            errors++;
            $display("FAIL R13: drive=%b data=%h expected drive=0 data=0", rd_drive_o, rd_data_o);
        end
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        do_reset(1'b0);
        // fill words 0..15 with chipset-opened write bursts
        tag = "R5";
        for (int b = 0; b < 16; b += 4) begin
            wr_set(6'(b), pat(b));
            for (int k = 1; k < 4; k++) adv_wr(pat(b + k));
        end
        tag = "R6";  // interleaved order from start 6: 6,7,4,5
        rd_cpu(6'd6); adv_rd(); adv_rd(); adv_rd();
        hold_rd(); hold_rd();
        adv_rd();    // count wraps back to the start word
        tag = "R3";
        rd_cpu(6'd13);
        tag = "R8";  // byte-masked write of lanes 0,2,5,7
        cyc(1, 0, 1, 0, 1, 0, 1, 0, 8'b0101_1010, 6'd9, 64'hffee_ddcc_bbaa_9988, 0, 0);
        rd_cpu(6'd9);
        cyc(1, 0, 1, 0, 1, 0, 1, 1, 8'h00, 6'd10, 64'h1111_2222_3333_4444, 0, 0);
        cyc(1, 0, 1, 0, 1, 0, 1, 0, 8'hff, 6'd11, 64'h5555_6666_7777_8888, 0, 0);
        rd_cpu(6'd10); rd_cpu(6'd11);
        tag = "R7";  // global write beats disabled byte controls
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 8'hff, 6'd12, 64'hdead_beef_cafe_f00d, 0, 0);
        rd_cpu(6'd12);
        tag = "R3";  // write inputs ignored by the processor strobe
        cyc(0, 1, 1, 0, 1, 0, 0, 0, 8'h00, 6'd3, 64'h0bad_0bad_0bad_0bad, 0, 0);
        tag = "R4";
        cyc(1, 1, 1, 0, 1, 0, 0, 1, 8'hff, 6'd0, 64'h4444_aaaa_4444_aaaa, 0, 0);
        rd_cpu(6'd3);
        tag = "R1";
        cyc(0, 1, 1, 1, 1, 0, 1, 1, 8'hff, 6'd14, 64'h0, 0, 0);
        desel(); adv_rd();
        cyc(0, 1, 1, 1, 1, 0, 1, 1, 8'hff, 6'd14, 64'h0, 0, 0);
        tag = "R2";
        rd_cpu(6'd1);
        cyc(1, 0, 1, 0, 0, 0, 1, 1, 8'hff, 6'd2, 64'h0, 0, 0);
        hold_rd();
        rd_cpu(6'd1);
        cyc(0, 1, 1, 0, 1, 1, 1, 1, 8'hff, 6'd2, 64'h0, 0, 0);
        hold_rd();
        tag = "R9";
        rd_cpu(6'd5);
        cyc(1, 1, 1, 0, 1, 0, 1, 1, 8'hff, 6'd0, 64'h0, 1, 0);
        wr_set(6'd15, 64'h1234_5678_9abc_def0);
        tag = "R11";
        rd_cpu(6'd0);
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 8'hff, 6'd0, 64'h9999_9999_9999_9999, 0, 1);
        cyc(0, 1, 1, 0, 1, 0, 1, 1, 8'hff, 6'd4, 64'h0, 0, 1);
        tag = "R12";
        for (int k = 0; k < WAKE; k++) rd_cpu(6'd0);
        tag = "R11";
        rd_cpu(6'd0);
        desel();
        repeat (3) @(negedge clk);

        // pipelined section
        do_reset(1'b1);
        tag = "R10";
        rd_cpu(6'd8); adv_rd(); adv_rd(); adv_rd();
        wr_set(6'd2, 64'h7777_0000_7777_0000);
        rd_cpu(6'd2);
        cyc(1, 0, 1, 0, 1, 0, 1, 0, 8'b1111_0000, 6'd2, 64'h0000_0000_abcd_ef01, 0, 0);
        rd_cpu(6'd2);
        desel();
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d expected slots unchecked, expected 0", sb.size());
        end
        finish_run();
    end
endmodule